// File: doc/BRIEF.md
# Multi-link word transfer scheduler

This block sits between eight serial link units and a shared, word-addressed storage. Each link raises a one-cycle request pulse when it has a fresh 32-bit word ready. The scheduler latches that pulse into a pending flag for the link. When it is free, it picks one pending link by round-robin and captures the link's word into a working register. It then offers the word to storage through a valid/ready write port.

The storage address packs three fields: the link number, the copy index the link presents, and the position of the word inside a 32-word message block. The scheduler keeps a word position for every link and copy pair. Because of this, service that hops between links resumes each message at the correct word. When a message block fills, the block raises a pulse on the link's done line. The whole block runs on the fast transfer clock. Request pulses are assumed to arrive already synchronous to that clock.

Top module: `link_xfer_sched`

## Requirements
- R1: A high bit on `req_i` at a rising edge sets that link's pending flag, which shows on `pend_o` after that edge and stays set until the link is captured.
- R2: Among pending links, the grant goes to the first one found scanning upward (wrapping 7 to 0) from the position one past the link captured last; after reset the scan starts at link 0.
- R3: At the edge where a link's word is captured, its pending flag clears (unless a new request for it arrives in that same cycle) and `mem_wvalid_o` rises.
- R4: `mem_waddr_o` is {link[2:0] in bits 9:7, copy[1:0] in bits 6:5, word position[4:0] in bits 4:0}; the copy comes from the link's 2-bit slice of `copy_i`, and `mem_wdata_o` is the link's 32-bit slice of `word_i`, both sampled at capture.
- R5: Each link and copy pair has its own word position. The position advances by one on every accepted write for that pair and wraps from 31 to 0. Other pairs are left unchanged.
- R6: While `mem_wvalid_o` is high and `mem_wready_i` is low, valid stays high and address and data stay stable; each capture produces exactly one accepted write.
- R7: `blk_done_o` has the served link's bit high during the cycle in which the write at word position 31 is accepted, and is zero at all other times.
- R8: A synchronous active-low reset clears all pending flags, all word positions, the round-robin start point and the write valid.
- R9: No new link is captured while a write is outstanding; pending flags of other links are held during a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Per-link word-ready request pulses |
| word_i | input | 256 | Per-link 32-bit words, link n in bits 32n+31:32n |
| copy_i | input | 16 | Per-link copy index, link n in bits 2n+1:2n |
| pend_o | output | 8 | Per-link pending flags |
| mem_wvalid_o | output | 1 | Storage write valid |
| mem_wready_i | input | 1 | Storage write ready |
| mem_waddr_o | output | 10 | Storage word address |
| mem_wdata_o | output | 32 | Storage write data |
| blk_done_o | output | 8 | Per-link message-block-complete pulse |

## Verification
A request pulse shows on `pend_o` one edge later. When the scheduler is idle, the capture follows at the next edge, so the flag clear and the rise of write valid appear two edges after the pulse. The write is accepted at the first edge at which ready is high, and `blk_done_o` is valid during that accept cycle. With ready held high, back-to-back pending links are served every second cycle. The bench drives its inputs and samples the outputs on falling edges. It checks the single-transfer latency at the exact falling edge, and it walks multi-link orderings and stalls one falling edge at a time, so each result is compared in the cycle it is due.

// File: rtl/lxs_pkg.sv
// Shared types for the multi-link word transfer scheduler.
package lxs_pkg;
    // Sequencer states: waiting for a pending link, or holding a storage write.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/lxs_rr_arbiter.sv
// Round-robin arbiter over NUM_LINKS pending flags.
// Scans upward from a start point, wrapping; the start point moves one past
// the winner when the caller advances. Assumes NUM_LINKS is a power of two.
module lxs_rr_arbiter #(
    parameter int NUM_LINKS = 8,
    localparam int LINK_W = $clog2(NUM_LINKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINKS-1:0] req,
    input  logic                 advance,
    output logic                 gnt_vld,
    output logic [LINK_W-1:0]    gnt_idx,
    output logic [NUM_LINKS-1:0] gnt_oh
);
    logic [LINK_W-1:0] start_q;

    // Pick the first requester at or after the start point.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = NUM_LINKS - 1; i >= 0; i--) begin
            if (req[LINK_W'(int'(start_q) + i)]) begin
                gnt_vld = 1'b1;
                gnt_idx = LINK_W'(int'(start_q) + i);
            end
        end
    end

    // Expand the winning index into a one-hot vector.
    always_comb begin
        gnt_oh = '0;
        if (gnt_vld) gnt_oh[gnt_idx] = 1'b1;
    end

    // Move the scan start one past the link just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)       start_q <= '0;
        else if (advance) start_q <= gnt_idx + 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh)); // R2
    AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> ((gnt_oh & req) != '0)); // R2
    AST_START_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (start_q == LINK_W'($past(gnt_idx) + 1'b1))); // R2
endmodule

// File: rtl/lxs_widx_bank.sv
// Word-position bank: one WIDX_W-bit counter per link and copy pair.
// A read port gives the position for the pair about to be captured. An
// increment port advances one pair after its write is accepted, wrapping.
module lxs_widx_bank #(
    parameter int NUM_LINKS = 8,
    parameter int COPY_W    = 2,
    parameter int WIDX_W    = 5,
    localparam int LINK_W    = $clog2(NUM_LINKS),
    localparam int SLOT_W    = LINK_W + COPY_W,
    localparam int NUM_SLOTS = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] rd_link,
    input  logic [COPY_W-1:0] rd_copy,
    output logic [WIDX_W-1:0] rd_widx,
    input  logic              inc_en,
    input  logic [LINK_W-1:0] inc_link,
    input  logic [COPY_W-1:0] inc_copy
);
    logic [WIDX_W-1:0] cnt_q [NUM_SLOTS];
    logic [SLOT_W-1:0] rd_slot;
    logic [SLOT_W-1:0] inc_slot;

    assign rd_slot  = {rd_link, rd_copy};
    assign inc_slot = {inc_link, inc_copy};
    assign rd_widx  = cnt_q[rd_slot];

    // Clear every position on reset; advance the served pair on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) cnt_q[s] <= '0;
        end else if (inc_en) begin
            cnt_q[inc_slot] <= cnt_q[inc_slot] + 1'b1;
        end
    end

    AST_WIDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |=> (cnt_q[$past(inc_slot)] == WIDX_W'($past(cnt_q[inc_slot]) + 1'b1))); // R5
endmodule

// File: rtl/link_xfer_sched.sv
// Multi-link word transfer scheduler (top).
// Latches per-link request pulses into pending flags and grants one link
// round-robin. It captures that link's word, copy index and word position
// into a working register and offers one valid/ready write to storage. The
// link's word position advances on accept. Assumes requests are synchronous
// to clk and that a link holds its word and copy steady until captured.
module link_xfer_sched #(
    parameter int NUM_LINKS = 8,
    parameter int DATA_W    = 32,
    parameter int COPY_W    = 2,
    parameter int WIDX_W    = 5,
    localparam int LINK_W   = $clog2(NUM_LINKS),
    localparam int ADDR_W   = LINK_W + COPY_W + WIDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINKS-1:0]        req_i,
    input  logic [NUM_LINKS*DATA_W-1:0] word_i,
    input  logic [NUM_LINKS*COPY_W-1:0] copy_i,
    output logic [NUM_LINKS-1:0]        pend_o,
    output logic                        mem_wvalid_o,
    input  logic                        mem_wready_i,
    output logic [ADDR_W-1:0]           mem_waddr_o,
    output logic [DATA_W-1:0]           mem_wdata_o,
    output logic [NUM_LINKS-1:0]        blk_done_o
);
    import lxs_pkg::*;

    xfer_state_e          state_q;
    logic [NUM_LINKS-1:0] pend_q;
    logic                 gnt_vld;
    logic [LINK_W-1:0]    gnt_idx;
    logic [NUM_LINKS-1:0] gnt_oh;
    logic                 capture;
    logic                 accept;
    logic [COPY_W-1:0]    sel_copy;
    logic [WIDX_W-1:0]    sel_widx;
    logic [LINK_W-1:0]    link_q;
    logic [COPY_W-1:0]    copy_q;
    logic [WIDX_W-1:0]    widx_q;
    logic [DATA_W-1:0]    data_q;

    assign capture  = (state_q == ST_IDLE) && gnt_vld;
    assign accept   = (state_q == ST_WRITE) && mem_wready_i;
    assign sel_copy = copy_i[COPY_W*int'(gnt_idx) +: COPY_W];

    lxs_rr_arbiter #(.NUM_LINKS(NUM_LINKS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pend_q),
        .advance (capture),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx),
        .gnt_oh  (gnt_oh)
    );

    lxs_widx_bank #(
        .NUM_LINKS (NUM_LINKS),
        .COPY_W    (COPY_W),
        .WIDX_W    (WIDX_W)
    ) u_widx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_link  (gnt_idx),
        .rd_copy  (sel_copy),
        .rd_widx  (sel_widx),
        .inc_en   (accept),
        .inc_link (link_q),
        .inc_copy (copy_q)
    );

    // Pending flags: cleared for the captured link, set by new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(capture ? gnt_oh : '0)) | req_i;
    end

    // Sequencer: capture when idle, hold the write until storage accepts.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= ST_IDLE;
        else if (capture) state_q <= ST_WRITE;
        else if (accept)  state_q <= ST_IDLE;
    end

    // Working register: link, copy, word position and data of the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= '0;
            copy_q <= '0;
            widx_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            link_q <= gnt_idx;
            copy_q <= sel_copy;
            widx_q <= sel_widx;
            data_q <= word_i[DATA_W*int'(gnt_idx) +: DATA_W];
        end
    end

    assign pend_o       = pend_q;
    assign mem_wvalid_o = (state_q == ST_WRITE);
    assign mem_waddr_o  = {link_q, copy_q, widx_q};
    assign mem_wdata_o  = data_q;

    // One done line per link, raised while the last word of a block is accepted.
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_done
        assign blk_done_o[g] = accept && (link_q == LINK_W'(g)) && (&widx_q);
    end

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && ((req_i & gnt_oh) == '0)) |=> ((pend_o & $past(gnt_oh)) == '0)); // R3
    AST_VALID_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> mem_wvalid_o); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid_o && !mem_wready_i) |=> (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o))); // R6
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid_o && mem_wready_i) |=> !mem_wvalid_o); // R6
    AST_NO_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid_o |=> (($past(pend_o) & ~pend_o) == '0)); // R9
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_done_o)); // R7
    AST_DONE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done_o != '0) |-> (mem_wvalid_o && mem_wready_i)); // R7
endmodule

// File: tb/tb_link_xfer_sched.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_link_xfer_sched;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   req_i = '0;
    logic [255:0] word_i = '0;
    logic [15:0]  copy_i = '0;
    logic [7:0]   pend_o;
    logic         mem_wvalid_o;
    logic         mem_wready_i = 1'b1;
    logic [9:0]   mem_waddr_o;
    logic [31:0]  mem_wdata_o;
    logic [7:0]   blk_done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int mcnt [8][4];

    link_xfer_sched dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .word_i(word_i),
        .copy_i(copy_i), .pend_o(pend_o), .mem_wvalid_o(mem_wvalid_o),
        .mem_wready_i(mem_wready_i), .mem_waddr_o(mem_waddr_o),
        .mem_wdata_o(mem_wdata_o), .blk_done_o(blk_done_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_i = '0;
        mem_wready_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int l = 0; l < 8; l++)
            for (int c = 0; c < 4; c++) mcnt[l][c] = 0;
    endtask

    // Load a link's word and copy index; takes effect immediately.
    task automatic load_link(input int link, input int copy, input logic [31:0] data);
        word_i[link*32 +: 32] = data;
        copy_i[link*2 +: 2] = 2'(copy);
    endtask

    // One-cycle request pulse; returns at the negedge after the setting edge.
    task automatic pulse_req(input logic [7:0] mask);
        @(negedge clk);
        req_i = mask;
        @(negedge clk);
        req_i = '0;
    endtask

    // Wait for the next write, compare address, data, flag, done; update model.
    task automatic expect_write(input string tag, input int link, input int copy,
                                input logic [31:0] data, input int max_wait);
        int waited = 0;
        logic [9:0] ea;
        @(negedge clk);
        while (!mem_wvalid_o && waited < max_wait) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " R3 valid"}, 32'(mem_wvalid_o), 32'h1);
        check({tag, " R3 flag clear"}, 32'(pend_o[link]), 32'h0);
        ea = {3'(link), 2'(copy), 5'(mcnt[link][copy])};
        check({tag, " R4 addr"}, 32'(mem_waddr_o), 32'(ea));
        check({tag, " R4 data"}, mem_wdata_o, data);
        if (mem_wready_i) begin
            check({tag, " R7 done"}, 32'(blk_done_o),
                  (mcnt[link][copy] == 31) ? 32'(1 << link) : 32'h0);
            mcnt[link][copy] = (mcnt[link][copy] + 1) % 32;
        end
    endtask

    task automatic t_reset_state();
        check("R8 reset valid", 32'(mem_wvalid_o), 32'h0);
        check("R8 reset pend", 32'(pend_o), 32'h0);
        check("R7 reset done", 32'(blk_done_o), 32'h0);
    endtask

    task automatic t_single();
        load_link(3, 1, 32'hC0DE_0301);
        pulse_req(8'h08);
        check("R1 pend set", 32'(pend_o), 32'h08);
        expect_write("single", 3, 1, 32'hC0DE_0301, 0);
        load_link(3, 1, 32'hC0DE_0302);
        pulse_req(8'h08);
        expect_write("second R5", 3, 1, 32'hC0DE_0302, 0);
        load_link(3, 2, 32'hC0DE_0320);
        pulse_req(8'h08);
        expect_write("other copy R5", 3, 2, 32'hC0DE_0320, 0);
        @(negedge clk);
        check("R6 one write", 32'(mem_wvalid_o), 32'h0);
    endtask

    // Last captured link is 3: order must be 5, 6, 1.
    task automatic t_round_robin();
        load_link(1, 0, 32'h1111_0001);
        load_link(5, 0, 32'h5555_0005);
        load_link(6, 0, 32'h6666_0006);
        pulse_req(8'b0110_0010);
        expect_write("rr first R2", 5, 0, 32'h5555_0005, 4);
        expect_write("rr second R2", 6, 0, 32'h6666_0006, 4);
        expect_write("rr third R2", 1, 0, 32'h1111_0001, 4);
    endtask

    // Stall with two links pending; last captured is 1, so 2 then 4.
    task automatic t_stall();
        load_link(2, 3, 32'h2222_0203);
        load_link(4, 0, 32'h4444_0400);
        @(negedge clk);
        mem_wready_i = 1'b0;
        pulse_req(8'b0001_0100);
        expect_write("stall R2", 2, 3, 32'h2222_0203, 4);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 hold valid", 32'(mem_wvalid_o), 32'h1);
            check("R6 hold addr", 32'(mem_waddr_o), 32'(10'({3'd2, 2'd3, 5'd0})));
            check("R6 hold data", mem_wdata_o, 32'h2222_0203);
            check("R9 other pending", 32'(pend_o), 32'h10);
        end
        mem_wready_i = 1'b1;
        mcnt[2][3] = 1;
        @(negedge clk);
        check("R6 single accept", 32'(mem_wvalid_o), 32'h0);
        expect_write("after stall R9", 4, 0, 32'h4444_0400, 4);
    endtask

    // Fill a whole block on link 0 copy 0 and check the wrap.
    task automatic t_wrap();
        for (int w = 0; w < 33; w++) begin
            load_link(0, 0, 32'hB10C_0000 + 32'(w));
            pulse_req(8'h01);
            expect_write("wrap R5", 0, 0, 32'hB10C_0000 + 32'(w), 0);
        end
        check("R5 wrapped pos", 32'(mcnt[0][0]), 32'h1);
    endtask

    task automatic t_reset_clears();
        load_link(7, 0, 32'h7777_0007);
        pulse_req(8'h80);
        do_reset();
        @(negedge clk);
        check("R8 pend cleared", 32'(pend_o), 32'h0);
        load_link(3, 1, 32'hAAAA_0301);
        load_link(0, 0, 32'hAAAA_0000);
        pulse_req(8'h09);
        expect_write("R8 start link0", 0, 0, 32'hAAAA_0000, 2);
        expect_write("R8 pos cleared", 3, 1, 32'hAAAA_0301, 4);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        t_reset_state();
        t_single();
        t_round_robin();
        t_stall();
        t_wrap();
        t_reset_clears();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule